// File: doc/BRIEF.md
# Full-Duplex Serial Peripheral Port (Master/Slave)

This block is a byte-wide synchronous serial port that runs either as the clock-driving master or as a slave clocked from outside. Both roles share one shift register. Each bit shifted out is replaced by a bit shifted in, so at the end of a byte the two ends have swapped contents. In master mode a host write to the data register starts a byte. The block holds its select output low for the whole byte and produces eight serial-clock pulses from a divided system clock. In slave mode the block follows an external serial clock, but only while the external select input is low.

A small register port gives the host a control byte, a status byte and a data byte. The control byte sets enable, role, bit order, rate field, double-speed bit and interrupt enable. The status byte has a byte-complete flag and a write-collision flag, and the host clears both with a read-status-then-touch-data sequence. The serial timing is fixed: the clock idles low, input bits are sampled on the rising edge and output bits change on the falling edge.

Top module: `spi_port`

## Requirements
- R1: After reset, ss_n_out is 1, sck_out is 0, miso_oe is 0, irq is 0 and the status byte reads 0.
- R2: With the block enabled in master mode and no byte in flight, a write to the data register (address 2) starts a byte. ss_n_out stays low for exactly 8 divisor periods, mosi_out carries the written byte, and the byte sampled from miso_in can then be read back at address 2.
- R3: The master divisor is 4, 16, 64 or 128 for rate field (control bits 1:0) values 0 to 3. Control bit 2 (double speed) halves it, giving 2, 8, 32 or 64. One serial-clock period lasts one divisor of system clocks.
- R4: sck_out idles low. mosi_out changes only on a falling serial-clock edge, and the first bit is present before the first rising edge.
- R5: Control bit 5 set shifts least significant bit first, and clear shifts most significant bit first. The setting applies to both the transmitted and the received byte.
- R6: Completion of a byte sets status bit 7. irq equals status bit 7 gated by control bit 7.
- R7: A data write while a byte is in flight sets status bit 6. The write is dropped, and the byte in flight completes with its original content.
- R8: Both flags clear on a data-register access (read or write) that follows a status read which saw a flag set. A data access with no such status read leaves the flags set.
- R9: In slave mode (control bit 6 set, bit 4 clear), the block samples mosi_in on rising sck_in and drives miso_out while ss_n_in is low. miso_oe is 1 only in that state. The received byte appears at address 2 after eight bits.
- R10: In slave mode, ss_n_in rising part-way through a byte discards the partial bit count without setting status bit 7, and the next full byte is received intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe |
| reg_addr | input | 2 | 0 control, 1 status, 2 data |
| reg_wdata | input | 8 | Host write data |
| reg_rdata | output | 8 | Host read data (combinational) |
| irq | output | 1 | Byte-complete interrupt request |
| sck_out | output | 1 | Master serial clock |
| ss_n_out | output | 1 | Master select, active low |
| mosi_out | output | 1 | Master serial data out |
| miso_in | input | 1 | Master serial data in |
| sck_in | input | 1 | Slave serial clock |
| ss_n_in | input | 1 | Slave select, active low |
| mosi_in | input | 1 | Slave serial data in |
| miso_out | output | 1 | Slave serial data out |
| miso_oe | output | 1 | Slave output enable for miso_out |

## Verification
The bench runs master bytes over all eight rate and double-speed settings in both bit orders, and it counts the select-low window in system clocks. A wrong divisor table, or a double-speed bit applied the wrong way, shows up as a window of the wrong length. A reversed shift direction shows up as a mirrored byte at one end. One byte is written over while still in flight: a design that let that write through would send a different pattern or leave the collision flag clear. The bench also reads the data register with no status read first, to catch flags that clear too easily. A slave byte is cut short by raising select, to catch a bit counter that survives and misaligns the next byte.

// File: rtl/spi_pkg.sv
package spi_pkg;
  localparam int unsigned BYTE_W = 8;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  typedef struct packed {
    logic       irq_en;
    logic       en;
    logic       lsb_first;
    logic       master;
    logic       spare;
    logic       dbl;
    logic [1:0] rate;
  } spi_ctrl_t;

  // System clocks per half serial-clock period.
  function automatic logic [7:0] half_period(input logic [1:0] rate, input logic dbl);
    logic [7:0] div;
    unique case (rate)
      2'd0:    div = 8'd4;
      2'd1:    div = 8'd16;
      2'd2:    div = 8'd64;
      default: div = 8'd128;
    endcase
    if (dbl) div = div >> 1;
    return div >> 1;
  endfunction
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[g] <= RST_VAL;
        else if (g == 0) st[g] <= d;
        else st[g] <= st[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/spi_clkgen.sv
module spi_clkgen #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] half,
  output logic             sck,
  output logic             rise_ev,
  output logic             fall_ev
);
  localparam logic [CNT_W-1:0] ONE = 1;
  logic [CNT_W-1:0] cnt;
  logic tick;

  assign tick    = run && (cnt == half - ONE);
  assign rise_ev = tick && !sck;
  assign fall_ev = tick && sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      sck <= ~sck;
    end else begin
      cnt <= cnt + ONE;
    end
  end
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         lsb_first,
  input  logic         rise_ev,
  input  logic         fall_ev,
  input  logic         clear_cnt,
  input  logic         sin,
  output logic         sout,
  output logic [W-1:0] next_word,
  output logic         byte_done
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] ONE  = 1;
  localparam logic [CW-1:0] LAST = CW'(W-1);

  logic [W-1:0]  sr;
  logic          samp;
  logic [CW-1:0] bitcnt;

  assign sout      = lsb_first ? sr[0] : sr[W-1];
  assign next_word = lsb_first ? {samp, sr[W-1:1]} : {sr[W-2:0], samp};
  assign byte_done = fall_ev && (bitcnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr     <= '0;
      samp   <= 1'b0;
      bitcnt <= '0;
    end else if (load) begin
      sr     <= load_data;
      bitcnt <= '0;
    end else begin
      if (rise_ev) samp <= sin;
      if (fall_ev) begin
        sr     <= next_word;
        bitcnt <= byte_done ? '0 : bitcnt + ONE;
      end
      if (clear_cnt) bitcnt <= '0;
    end
  end
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  output logic       sck_out,
  output logic       ss_n_out,
  output logic       mosi_out,
  input  logic       miso_in,
  input  logic       sck_in,
  input  logic       ss_n_in,
  input  logic       mosi_in,
  output logic       miso_out,
  output logic       miso_oe
);
  spi_ctrl_t         ctrl;
  logic              busy, done_f, coll_f, armed, sck_prev;
  logic [BYTE_W-1:0] rx_buf, next_word;
  logic              sck_s, ss_n_s, mosi_s;
  logic              m_sck, m_rise, m_fall;
  logic              rise_ev, fall_ev, sout, byte_done;

  // Named events used by the datapath and by the checker.
  logic is_master, is_slave, slave_sel, in_progress;
  logic data_wr, data_acc, stat_rd;
  logic coll_ev, xfer_start, load, flag_clr, clear_cnt;

  spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({sck_in, ss_n_in, mosi_in}),
    .q({sck_s, ss_n_s, mosi_s})
  );

  assign is_master   = ctrl.en && ctrl.master;
  assign is_slave    = ctrl.en && !ctrl.master;
  assign slave_sel   = is_slave && !ss_n_s;
  assign in_progress = busy || slave_sel;

  assign data_wr    = reg_wr && (reg_addr == ADDR_DATA);
  assign data_acc   = (reg_wr || reg_rd) && (reg_addr == ADDR_DATA);
  assign stat_rd    = reg_rd && (reg_addr == ADDR_STAT);
  assign coll_ev    = data_wr && in_progress;
  assign load       = data_wr && !in_progress;
  assign xfer_start = load && is_master;
  assign flag_clr   = data_acc && armed;
  assign clear_cnt  = !busy && !slave_sel;

  spi_clkgen #(.CNT_W(CNT_W)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .run(busy),
    .half(CNT_W'(half_period(ctrl.rate, ctrl.dbl))),
    .sck(m_sck), .rise_ev(m_rise), .fall_ev(m_fall)
  );

  assign rise_ev = is_master ? m_rise : (slave_sel && sck_s && !sck_prev);
  assign fall_ev = is_master ? m_fall : (slave_sel && !sck_s && sck_prev);

  spi_shifter #(.W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .load_data(reg_wdata),
    .lsb_first(ctrl.lsb_first), .rise_ev(rise_ev), .fall_ev(fall_ev),
    .clear_cnt(clear_cnt), .sin(is_master ? miso_in : mosi_s),
    .sout(sout), .next_word(next_word), .byte_done(byte_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl     <= '0;
      busy     <= 1'b0;
      done_f   <= 1'b0;
      coll_f   <= 1'b0;
      armed    <= 1'b0;
      sck_prev <= 1'b0;
      rx_buf   <= '0;
    end else begin
      sck_prev <= sck_s;
      if (reg_wr && (reg_addr == ADDR_CTRL)) ctrl <= spi_ctrl_t'(reg_wdata);

      if (!is_master)     busy <= 1'b0;
      else if (xfer_start) busy <= 1'b1;
      else if (byte_done)  busy <= 1'b0;

      if (byte_done) rx_buf <= next_word;

      if (byte_done)     done_f <= 1'b1;
      else if (flag_clr) done_f <= 1'b0;

      if (coll_ev)       coll_f <= 1'b1;
      else if (flag_clr) coll_f <= 1'b0;

      if (stat_rd && (done_f || coll_f)) armed <= 1'b1;
      else if (data_acc)                 armed <= 1'b0;
    end
  end

  always_comb begin
    unique case (reg_addr)
      ADDR_CTRL: reg_rdata = ctrl;
      ADDR_STAT: reg_rdata = {done_f, coll_f, 6'b0};
      ADDR_DATA: reg_rdata = rx_buf;
      default:   reg_rdata = '0;
    endcase
  end

  assign irq      = ctrl.irq_en && done_f;
  assign sck_out  = is_master && m_sck;
  assign ss_n_out = !busy;
  assign mosi_out = is_master && sout;
  assign miso_out = sout;
  assign miso_oe  = slave_sel;
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic sck_out,
  input logic ss_n_out,
  input logic mosi_out,
  input logic miso_oe,
  input logic is_master,
  input logic rise_ev,
  input logic fall_ev,
  input logic byte_done,
  input logic coll_ev,
  input logic flag_clr,
  input logic done_f,
  input logic coll_f
);
  assert_sck_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck_out);
  assert_sck_within_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sck_out |-> !ss_n_out);
  assert_mosi_on_fall_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(fall_ev)) |-> $stable(mosi_out));
  assert_edges_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_ev && fall_ev));
  assert_done_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> done_f);
  assert_collision_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    coll_ev |=> coll_f);
  assert_flag_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !byte_done && !coll_ev) |=> (!done_f && !coll_f));
  assert_no_drive_as_master_R9: assert property (@(posedge clk) disable iff (!rst_n)
    is_master |-> !miso_oe);
endmodule

bind spi_port spi_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .sck_out(sck_out), .ss_n_out(ss_n_out),
  .mosi_out(mosi_out), .miso_oe(miso_oe), .is_master(is_master),
  .rise_ev(rise_ev), .fall_ev(fall_ev), .byte_done(byte_done),
  .coll_ev(coll_ev), .flag_clr(flag_clr), .done_f(done_f), .coll_f(coll_f)
);

// File: tb/sim_spi_port.sv
module sim_spi_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       irq, sck_out, ss_n_out, mosi_out, miso_out, miso_oe;
  logic       miso_in = 1'b0, sck_in = 1'b0, ss_n_in = 1'b1, mosi_in = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [7:0] slave_got, miso_got;

  spi_port u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .sck_out(sck_out), .ss_n_out(ss_n_out), .mosi_out(mosi_out), .miso_in(miso_in),
    .sck_in(sck_in), .ss_n_in(ss_n_in), .mosi_in(mosi_in),
    .miso_out(miso_out), .miso_oe(miso_oe)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  function automatic int divisor(input int rate, input bit dbl);
    int d = (rate == 3) ? 128 : (4 << (2 * rate));
    return dbl ? d / 2 : d;
  endfunction

  function automatic logic bit_at(input logic [7:0] b, input int k, input bit lsb);
    return lsb ? b[k] : b[7-k];
  endfunction

  // Bench-side slave for master-mode runs: mode 0 timing.
  task automatic far_slave(input logic [7:0] tx, input bit lsb);
    slave_got = 8'h00;
    wait (ss_n_out == 1'b0);
    miso_in = bit_at(tx, 0, lsb);
    for (int k = 0; k < 8; k++) begin
      @(posedge sck_out);
      if (lsb) slave_got[k] = mosi_out; else slave_got[7-k] = mosi_out;
      @(negedge sck_out);
      if (k < 7) miso_in = bit_at(tx, k + 1, lsb);
    end
  endtask

  task automatic start_and_time(input logic [7:0] tx, output int cnt);
    wr(2'd2, tx);
    cnt = 0;
    while (!ss_n_out && cnt < 5000) begin
      cnt++;
      @(negedge clk);
    end
  endtask

  task automatic master_byte(input int rate, input bit dbl, input bit lsb,
                             input logic [7:0] tx, input logic [7:0] stx);
    int cnt;
    logic [7:0] v;
    wr(2'd0, {1'b1, 1'b1, lsb, 1'b1, 1'b0, dbl, 2'(rate)});
    fork
      far_slave(stx, lsb);
      start_and_time(tx, cnt);
    join
    check("R3", "select-low cycles", cnt, 8 * divisor(rate, dbl));
    check(lsb ? "R5" : "R2", "mosi byte", slave_got, tx);
    check("R6", "irq", irq, 1'b1);
    rd(2'd1, v);
    check("R6", "status after byte", v, 8'h80);
    rd(2'd2, v);
    check(lsb ? "R5" : "R2", "received byte", v, stx);
    rd(2'd1, v);
    check("R8", "status after clear", v, 8'h00);
  endtask

  // External master driving the block in slave mode.
  task automatic ext_master(input logic [7:0] mtx, input bit lsb, input int nbits);
    miso_got = 8'h00;
    @(negedge clk);
    ss_n_in = 1'b0;
    repeat (6) @(negedge clk);
    for (int k = 0; k < nbits; k++) begin
      mosi_in = bit_at(mtx, k, lsb);
      repeat (6) @(negedge clk);
      sck_in = 1'b1;
      if (lsb) miso_got[k] = miso_out; else miso_got[7-k] = miso_out;
      repeat (6) @(negedge clk);
      sck_in = 1'b0;
    end
    repeat (6) @(negedge clk);
    ss_n_in = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1", "ss_n_out", ss_n_out, 1'b1);
    check("R1", "sck_out", sck_out, 1'b0);
    check("R1", "miso_oe", miso_oe, 1'b0);
    check("R1", "irq", irq, 1'b0);
    rd(2'd1, v);
    check("R1", "status", v, 8'h00);

    // R2 R3 R4 R5 R6: sweep every rate, double-speed and order setting
    for (int r = 0; r < 4; r++)
      for (int d = 0; d < 2; d++)
        for (int l = 0; l < 2; l++)
          master_byte(r, d[0], l[0], 8'hA5 ^ 8'(r * 37 + d * 11 + l * 3),
                      8'h3C ^ 8'(r * 71 + d * 5 + l * 29));

    // R8: data access without prior status read keeps flags; R6: irq gated off
    wr(2'd0, {1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2'd0});
    fork
      far_slave(8'h81, 1'b0);
      start_and_time(8'h7E, cnt);
    join
    check("R6", "irq with enable clear", irq, 1'b0);
    rd(2'd2, v);
    check("R2", "received byte", v, 8'h81);
    rd(2'd1, v);
    check("R8", "flag kept without status read", v, 8'h80);
    rd(2'd2, v);
    rd(2'd1, v);
    check("R8", "flag cleared after sequence", v, 8'h00);

    // R7: collision during a slow byte
    wr(2'd0, {1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd2});
    fork
      far_slave(8'h5A, 1'b0);
      begin
        wr(2'd2, 8'hC3);
        repeat (100) @(negedge clk);
        wr(2'd2, 8'h0F);
        cnt = 0;
        while (!ss_n_out && cnt < 5000) begin cnt++; @(negedge clk); end
      end
    join
    check("R7", "byte sent unchanged", slave_got, 8'hC3);
    rd(2'd1, v);
    check("R7", "status both flags", v, 8'hC0);
    rd(2'd2, v);
    check("R7", "received byte", v, 8'h5A);
    rd(2'd1, v);
    check("R8", "both flags cleared", v, 8'h00);

    // R9: slave mode, both bit orders
    for (int l = 0; l < 2; l++) begin
      wr(2'd0, {1'b0, 1'b1, l[0], 1'b0, 1'b0, 1'b0, 2'd0});
      wr(2'd2, l[0] ? 8'hD2 : 8'h4B);
      check("R9", "miso_oe with select high", miso_oe, 1'b0);
      fork
        ext_master(l[0] ? 8'h1E : 8'hE7, l[0], 8);
        begin
          wait (ss_n_in == 1'b0);
          repeat (5) @(negedge clk);
          check("R9", "miso_oe with select low", miso_oe, 1'b1);
        end
      join
      check("R9", "miso_oe after select", miso_oe, 1'b0);
      check(l[0] ? "R5" : "R9", "miso byte", miso_got, l[0] ? 8'hD2 : 8'h4B);
      rd(2'd1, v);
      check("R9", "status after slave byte", v, 8'h80);
      rd(2'd2, v);
      check(l[0] ? "R5" : "R9", "slave received", v, l[0] ? 8'h1E : 8'hE7);
    end

    // R10: select released mid-byte
    wr(2'd0, {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0});
    ext_master(8'hFF, 1'b0, 3);
    rd(2'd1, v);
    check("R10", "no flag after partial byte", v, 8'h00);
    ext_master(8'h96, 1'b0, 8);
    rd(2'd1, v);
    check("R10", "flag after full byte", v, 8'h80);
    rd(2'd2, v);
    check("R10", "byte after abort", v, 8'h96);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule